// File: doc/BRIEF.md
# SPI Controller Register and Interrupt Front-End

This block is the 32-bit memory-mapped register slave that sits in front of a multi-channel SPI controller. It decodes a bank of module-wide registers and one window of registers per channel. It owns the module-wide registers: system configuration, system test, module control, wakeup enable, interrupt enable and interrupt status. It also merges the per-channel transmit-empty and receive-full events into a single level interrupt.

Per-channel registers are not stored here. An access to a channel window turns into a one-cycle read or write strobe for that channel, with a register index and the write data. The channel sequencer answers reads on a shared read-data input. Bus accesses complete in one cycle. Read data is combinational from the registers, and writes take effect at the clock edge that ends the access.

Top module: `spi_cfg_frontend`

## Requirements
- R1: After reset, interrupt status, interrupt enable, system configuration, wakeup enable, system test and module control all read 0, and irqOut is low. Revision (offset 0x00) reads the REVISION parameter, and system status (0x14) reads 1 at all times.
- R2: Written values are masked before they are stored: system configuration (0x10) with 0x31D, interrupt enable (0x1C) with 0x1777F, wakeup enable (0x20) with 0x1, system test (0x24) with 0xFFF, and module control (0x28) with 0xF.
- R3: Writes to revision and system status leave their read values unchanged. A write to a channel status register (index 1) or a receive register (index 4) raises no channel write strobe.
- R4: Channel n occupies 0x2C+0x14*n up to 0x2C+0x14*n+0x10. Its register index is the word offset inside the window: 0 config, 1 status, 2 control, 3 transmit, 4 receive. An access there raises bit n of chWrStb or chRdStb for that cycle, drives chRegIdx and chWdata, and a read returns chRdata. At most one strobe bit is high.
- R5: A txEmptyEvt[n] pulse sets interrupt status bit 4n at the next edge.
- R6: A rxFullEvt[n] pulse sets interrupt status bit 4n+2 at the next edge, but only when txOnlyMode[n] and turboMode[n] are both low.
- R7: irqOut is high exactly when some bit is set in both interrupt status and interrupt enable.
- R8: Writing interrupt status (0x18) clears each bit written as 1 and keeps each bit written as 0. A bit that is set by an event in the same cycle ends up set.
- R9: While module control bit 3 and system test bit 11 are both set, a write to interrupt status changes nothing.
- R10: A system-configuration write with bit 1 set returns every module register to its reset value and raises softRstPulse during that access.
- R11: An access with busFull low, or with busAddr[1:0] nonzero, reads 0, changes no register and raises no strobe.
- R12: Reads of addresses that map to no register (for example 0x04, or at and beyond the end of the last channel window) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Access present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busFull | input | 1 | 1 = full 32-bit access |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| txEmptyEvt | input | NCH | Per-channel transmit-empty event pulse |
| rxFullEvt | input | NCH | Per-channel receive-full event pulse |
| txOnlyMode | input | NCH | Channel is in transmit-only mode |
| turboMode | input | NCH | Channel has turbo enabled |
| irqOut | output | 1 | Interrupt request |
| softRstPulse | output | 1 | Soft reset request to the channels |
| chWrStb | output | NCH | Channel register write strobe |
| chRdStb | output | NCH | Channel register read strobe |
| chRegIdx | output | 3 | Register index inside the channel window |
| chWdata | output | 32 | Write data to the channel |
| chRdata | input | 32 | Read data from the addressed channel |

## Verification
The bench targets the interrupt-status corners. An event that coincides with a clearing write must survive; a design where the clear wins would lose that interrupt. A clearing write made while the test override is active must leave status untouched; a design without the gate would drop pending interrupts. Receive-full events in turbo or transmit-only mode must be ignored; a design that skipped this qualification would raise spurious interrupts. It also probes the window boundaries, the read-only channel registers, narrow and unaligned accesses, and soft reset. A wrong decode there would strobe the wrong channel or corrupt stored configuration.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam logic [31:0] OFS_REV      = 32'h00;
  localparam logic [31:0] OFS_SYSCFG   = 32'h10;
  localparam logic [31:0] OFS_SYSSTAT  = 32'h14;
  localparam logic [31:0] OFS_IRQSTAT  = 32'h18;
  localparam logic [31:0] OFS_IRQEN    = 32'h1C;
  localparam logic [31:0] OFS_WAKE     = 32'h20;
  localparam logic [31:0] OFS_SYSTEST  = 32'h24;
  localparam logic [31:0] OFS_MODCTRL  = 32'h28;
  localparam logic [31:0] CH_BASE      = 32'h2C;
  localparam logic [31:0] CH_STRIDE    = 32'h14;

  localparam logic [31:0] MASK_SYSCFG  = 32'h0000_031D;
  localparam logic [31:0] MASK_IRQEN   = 32'h0001_777F;
  localparam logic [31:0] MASK_WAKE    = 32'h0000_0001;
  localparam logic [31:0] MASK_SYSTEST = 32'h0000_0FFF;
  localparam logic [31:0] MASK_MODCTRL = 32'h0000_000F;

  localparam logic [2:0] IDX_STATUS  = 3'd1;
  localparam logic [2:0] IDX_RECEIVE = 3'd4;

  typedef enum logic [3:0] {
    RD_NONE, RD_REV, RD_SYSCFG, RD_SYSSTAT, RD_IRQSTAT,
    RD_IRQEN, RD_WAKE, RD_SYSTEST, RD_MODCTRL, RD_CHAN
  } rdSrc_e;

  typedef struct packed {
    logic   wrSysCfg;
    logic   softRst;
    logic   wrIrqStat;
    logic   wrIrqEn;
    logic   wrWake;
    logic   wrSysTest;
    logic   wrModCtrl;
    rdSrc_e rdSrc;
  } regStb_t;

  function automatic logic [31:0] chBase(int c);
    return CH_BASE + CH_STRIDE * 32'(c);
  endfunction

endpackage

// File: rtl/spi_cfg_decode.sv
module spi_cfg_decode
  import spi_cfg_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busFull,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              softBit,
  output regStb_t           stb,
  output logic [NCH-1:0]    chWrStb,
  output logic [NCH-1:0]    chRdStb,
  output logic [2:0]        chRegIdx
);

  logic        accessOk;
  logic [31:0] addr32;

  assign accessOk = busValid && busFull && (busAddr[1:0] == 2'b00);
  assign addr32   = 32'(busAddr);

  always_comb begin
    stb       = '0;
    stb.rdSrc = RD_NONE;
    chWrStb   = '0;
    chRdStb   = '0;
    chRegIdx  = '0;
    if (accessOk) begin
      case (addr32)
        OFS_REV:     stb.rdSrc = RD_REV;
        OFS_SYSSTAT: stb.rdSrc = RD_SYSSTAT;
        OFS_SYSCFG: begin
          stb.rdSrc    = RD_SYSCFG;
          stb.softRst  = busWrite && softBit;
          stb.wrSysCfg = busWrite && !softBit;
        end
        OFS_IRQSTAT: begin
          stb.rdSrc     = RD_IRQSTAT;
          stb.wrIrqStat = busWrite;
        end
        OFS_IRQEN: begin
          stb.rdSrc   = RD_IRQEN;
          stb.wrIrqEn = busWrite;
        end
        OFS_WAKE: begin
          stb.rdSrc  = RD_WAKE;
          stb.wrWake = busWrite;
        end
        OFS_SYSTEST: begin
          stb.rdSrc     = RD_SYSTEST;
          stb.wrSysTest = busWrite;
        end
        OFS_MODCTRL: begin
          stb.rdSrc     = RD_MODCTRL;
          stb.wrModCtrl = busWrite;
        end
        default: ;
      endcase
      for (int c = 0; c < NCH; c++) begin
        if (addr32 >= chBase(c) && addr32 < chBase(c + 1)) begin
          chRegIdx  = 3'((addr32 - chBase(c)) >> 2);
          stb.rdSrc = RD_CHAN;
          if (busWrite)
            chWrStb[c] = (chRegIdx != IDX_STATUS) && (chRegIdx != IDX_RECEIVE);
          else
            chRdStb[c] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int          NCH      = 4,
  parameter logic [31:0] REVISION = 32'h0000_0010
) (
  input  logic           clk,
  input  logic           rstN,
  input  regStb_t        stb,
  input  logic [31:0]    wdata,
  input  logic [NCH-1:0] txEmptyEvt,
  input  logic [NCH-1:0] rxFullEvt,
  input  logic [NCH-1:0] txOnlyMode,
  input  logic [NCH-1:0] turboMode,
  input  logic [31:0]    chRdata,
  output logic [31:0]    rdata,
  output logic [31:0]    irqStatQ,
  output logic           ovrActive,
  output logic           irqOut
);

  logic [31:0] sysCfgQ, irqEnQ, wakeQ, sysTestQ, modCtrlQ;
  logic [31:0] setVec, clrVec;

  assign ovrActive = modCtrlQ[3] && sysTestQ[11];

  always_comb begin
    setVec = '0;
    for (int c = 0; c < NCH; c++) begin
      setVec[4*c]     = txEmptyEvt[c];
      setVec[4*c + 2] = rxFullEvt[c] && !txOnlyMode[c] && !turboMode[c];
    end
    clrVec = (stb.wrIrqStat && !ovrActive) ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysCfgQ  <= '0;
      irqStatQ <= '0;
      irqEnQ   <= '0;
      wakeQ    <= '0;
      sysTestQ <= '0;
      modCtrlQ <= '0;
    end else if (stb.softRst) begin
      sysCfgQ  <= '0;
      irqStatQ <= '0;
      irqEnQ   <= '0;
      wakeQ    <= '0;
      sysTestQ <= '0;
      modCtrlQ <= '0;
    end else begin
      irqStatQ <= (irqStatQ & ~clrVec) | setVec;
      if (stb.wrSysCfg)  sysCfgQ  <= wdata & MASK_SYSCFG;
      if (stb.wrIrqEn)   irqEnQ   <= wdata & MASK_IRQEN;
      if (stb.wrWake)    wakeQ    <= wdata & MASK_WAKE;
      if (stb.wrSysTest) sysTestQ <= wdata & MASK_SYSTEST;
      if (stb.wrModCtrl) modCtrlQ <= wdata & MASK_MODCTRL;
    end
  end

  assign irqOut = |(irqStatQ & irqEnQ);

  always_comb begin
    case (stb.rdSrc)
      RD_REV:     rdata = REVISION;
      RD_SYSCFG:  rdata = sysCfgQ;
      RD_SYSSTAT: rdata = 32'h1;
      RD_IRQSTAT: rdata = irqStatQ;
      RD_IRQEN:   rdata = irqEnQ;
      RD_WAKE:    rdata = wakeQ;
      RD_SYSTEST: rdata = sysTestQ;
      RD_MODCTRL: rdata = modCtrlQ;
      RD_CHAN:    rdata = chRdata;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_cfg_frontend.sv
module spi_cfg_frontend
  import spi_cfg_pkg::*;
#(
  parameter int          NCH      = 4,
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] REVISION = 32'h0000_0010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busFull,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [NCH-1:0]    txEmptyEvt,
  input  logic [NCH-1:0]    rxFullEvt,
  input  logic [NCH-1:0]    txOnlyMode,
  input  logic [NCH-1:0]    turboMode,
  output logic              irqOut,
  output logic              softRstPulse,
  output logic [NCH-1:0]    chWrStb,
  output logic [NCH-1:0]    chRdStb,
  output logic [2:0]        chRegIdx,
  output logic [31:0]       chWdata,
  input  logic [31:0]       chRdata
);

  regStb_t     stb;
  logic [31:0] irqStatQ;
  logic        ovrActive;

  spi_cfg_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) uDecode (
    .busValid (busValid),
    .busWrite (busWrite),
    .busFull  (busFull),
    .busAddr  (busAddr),
    .softBit  (busWdata[1]),
    .stb      (stb),
    .chWrStb  (chWrStb),
    .chRdStb  (chRdStb),
    .chRegIdx (chRegIdx)
  );

  spi_cfg_regs #(.NCH(NCH), .REVISION(REVISION)) uRegs (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wdata      (busWdata),
    .txEmptyEvt (txEmptyEvt),
    .rxFullEvt  (rxFullEvt),
    .txOnlyMode (txOnlyMode),
    .turboMode  (turboMode),
    .chRdata    (chRdata),
    .rdata      (busRdata),
    .irqStatQ   (irqStatQ),
    .ovrActive  (ovrActive),
    .irqOut     (irqOut)
  );

  assign softRstPulse = stb.softRst;
  assign chWdata      = busWdata;

endmodule

// File: rtl/spi_cfg_frontend_chk.sv
module spi_cfg_frontend_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           busValid,
  input logic           busWrite,
  input logic           narrowAcc,
  input logic [NCH-1:0] chWrStb,
  input logic [NCH-1:0] chRdStb,
  input logic [2:0]     chRegIdx,
  input logic           softRstPulse,
  input logic           wrIrqStat,
  input logic           ovrActive,
  input logic [31:0]    irqStatQ,
  input logic [NCH-1:0] txEmptyEvt,
  input logic [NCH-1:0] rxFullEvt,
  input logic [NCH-1:0] txOnlyMode,
  input logic [NCH-1:0] turboMode
);

  assert_onehot_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chWrStb | chRdStb) && ((chWrStb & chRdStb) == '0));

  assert_ro_chan_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && (chRegIdx == 3'd1 || chRegIdx == 3'd4)) |-> (chWrStb == '0));

  assert_narrow_drop_R11: assert property (@(posedge clk) disable iff (!rstN)
    narrowAcc |-> (chWrStb == '0 && chRdStb == '0 && !softRstPulse));

  assert_override_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrIrqStat && ovrActive) |=> ((irqStatQ & $past(irqStatQ)) == $past(irqStatQ)));

  for (genvar c = 0; c < NCH; c++) begin : gChan
    assert_setwins_R8: assert property (@(posedge clk) disable iff (!rstN)
      (txEmptyEvt[c] && !softRstPulse) |=> irqStatQ[4*c]);

    assert_rxset_R6: assert property (@(posedge clk) disable iff (!rstN)
      (rxFullEvt[c] && !txOnlyMode[c] && !turboMode[c] && !softRstPulse) |=> irqStatQ[4*c + 2]);
  end

endmodule

bind spi_cfg_frontend spi_cfg_frontend_chk #(.NCH(NCH)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .busValid     (busValid),
  .busWrite     (busWrite),
  .narrowAcc    (busValid && (!busFull || busAddr[1:0] != 2'b00)),
  .chWrStb      (chWrStb),
  .chRdStb      (chRdStb),
  .chRegIdx     (chRegIdx),
  .softRstPulse (softRstPulse),
  .wrIrqStat    (stb.wrIrqStat),
  .ovrActive    (ovrActive),
  .irqStatQ     (irqStatQ),
  .txEmptyEvt   (txEmptyEvt),
  .rxFullEvt    (rxFullEvt),
  .txOnlyMode   (txOnlyMode),
  .turboMode    (turboMode)
);

// File: tb/tb_spi_cfg_frontend.sv
module tb_spi_cfg_frontend;

  localparam int          NCH = 4;
  localparam int          ADDR_W = 8;
  localparam logic [31:0] REV = 32'h0000_0010;
  localparam int          NVEC = 10;

  // write address, write data, readback address, expected readback
  localparam logic [31:0] V_WADDR [NVEC] = '{32'h10, 32'h1C, 32'h20, 32'h24, 32'h28,
                                             32'h00, 32'h14, 32'h08, 32'h28, 32'h24};
  localparam logic [31:0] V_WDATA [NVEC] = '{32'hFFFF_FFFD, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                             32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0,
                                             32'hFFFF_FFFF, 32'h5, 32'h123};
  localparam logic [31:0] V_RADDR [NVEC] = '{32'h10, 32'h1C, 32'h20, 32'h24, 32'h28,
                                             32'h00, 32'h14, 32'h08, 32'h28, 32'h24};
  localparam logic [31:0] V_EXP   [NVEC] = '{32'h31D, 32'h1777F, 32'h1, 32'hFFF, 32'hF,
                                             REV, 32'h1, 32'h0, 32'h5, 32'h123};
  // entries 0-4, 8, 9: R2 masks; 5, 6: R3 read-only; 7: R12 unmapped

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0, busFull = 1'b1;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata, chWdata;
  logic [31:0] chRdata = 32'hA5C3_0F96;
  logic [NCH-1:0] txEmptyEvt = '0, rxFullEvt = '0, txOnlyMode = '0, turboMode = '0;
  logic [NCH-1:0] chWrStb, chRdStb;
  logic [2:0] chRegIdx;
  logic irqOut, softRstPulse;

  int checks = 0;
  int errors = 0;

  logic [31:0] obsRdata, obsWdata;
  logic [NCH-1:0] obsWr, obsRd;
  logic [2:0] obsIdx;
  logic obsSoft;

  always #5 clk = ~clk;

  spi_cfg_frontend #(.NCH(NCH), .ADDR_W(ADDR_W), .REVISION(REV)) dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busFull(busFull),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txEmptyEvt(txEmptyEvt), .rxFullEvt(rxFullEvt), .txOnlyMode(txOnlyMode),
    .turboMode(turboMode), .irqOut(irqOut), .softRstPulse(softRstPulse),
    .chWrStb(chWrStb), .chRdStb(chRdStb), .chRegIdx(chRegIdx), .chWdata(chWdata),
    .chRdata(chRdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic full, input logic [31:0] addr,
                        input logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busFull = full;
    busAddr = ADDR_W'(addr); busWdata = data;
    #2;
    obsRdata = busRdata; obsWr = chWrStb; obsRd = chRdStb;
    obsIdx = chRegIdx; obsSoft = softRstPulse; obsWdata = chWdata;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; busFull = 1'b1;
  endtask

  task automatic rd(input logic [31:0] addr, output logic [31:0] val);
    access(1'b0, 1'b1, addr, 32'h0);
    val = obsRdata;
  endtask

  task automatic wr(input logic [31:0] addr, input logic [31:0] data);
    access(1'b1, 1'b1, addr, data);
  endtask

  task automatic pulseTx(input int c);
    @(negedge clk); txEmptyEvt[c] = 1'b1;
    @(negedge clk); txEmptyEvt[c] = 1'b0;
  endtask

  task automatic pulseRx(input int c);
    @(negedge clk); rxFullEvt[c] = 1'b1;
    @(negedge clk); rxFullEvt[c] = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1 chk("R1 irqOut", 32'(irqOut), 32'h0);
    rd(32'h18, v); chk("R1 irq status", v, 32'h0);
    rd(32'h1C, v); chk("R1 irq enable", v, 32'h0);
    rd(32'h10, v); chk("R1 sysconfig", v, 32'h0);
    rd(32'h28, v); chk("R1 modctrl", v, 32'h0);
    rd(32'h24, v); chk("R1 systest", v, 32'h0);
    rd(32'h20, v); chk("R1 wakeup", v, 32'h0);
    rd(32'h00, v); chk("R1 revision", v, REV);
    rd(32'h14, v); chk("R1 sysstatus", v, 32'h1);

    // table walk: R2 masks, R3 read-only, R12 unmapped
    for (int i = 0; i < NVEC; i++) begin
      wr(V_WADDR[i], V_WDATA[i]);
      rd(V_RADDR[i], v);
      chk($sformatf("R2/R3/R12 vector %0d", i), v, V_EXP[i]);
    end

    // R10 soft reset
    wr(32'h10, 32'h0000_0002);
    chk("R10 softRstPulse", 32'(obsSoft), 32'h1);
    rd(32'h1C, v); chk("R10 irq enable cleared", v, 32'h0);
    rd(32'h28, v); chk("R10 modctrl cleared", v, 32'h0);
    rd(32'h24, v); chk("R10 systest cleared", v, 32'h0);
    rd(32'h10, v); chk("R10 sysconfig cleared", v, 32'h0);
    rd(32'h20, v); chk("R10 wakeup cleared", v, 32'h0);

    // R5 transmit-empty event on channel 1 -> bit 4
    pulseTx(1);
    rd(32'h18, v); chk("R5 tx empty ch1 bit4", v, 32'h10);
    #1 chk("R7 irqOut masked", 32'(irqOut), 32'h0);
    wr(32'h1C, 32'h10);
    #1 chk("R7 irqOut enabled", 32'(irqOut), 32'h1);

    // R6 receive-full qualification on channel 3 -> bit 14
    turboMode[3] = 1'b1; pulseRx(3); turboMode[3] = 1'b0;
    rd(32'h18, v); chk("R6 turbo blocks", v, 32'h10);
    txOnlyMode[3] = 1'b1; pulseRx(3); txOnlyMode[3] = 1'b0;
    rd(32'h18, v); chk("R6 tx-only blocks", v, 32'h10);
    pulseRx(3);
    rd(32'h18, v); chk("R6 rx full ch3 bit14", v, 32'h4010);

    // R8 write-one-to-clear
    wr(32'h18, 32'h10);
    rd(32'h18, v); chk("R8 clear bit4 only", v, 32'h4000);
    #1 chk("R7 irqOut after clear", 32'(irqOut), 32'h0);
    // R8 set wins over a same-cycle clear
    @(negedge clk); txEmptyEvt[0] = 1'b1;
    wr(32'h18, 32'h1);
    txEmptyEvt[0] = 1'b0;
    rd(32'h18, v); chk("R8 set wins", v, 32'h4001);

    // R9 test override blocks clears
    wr(32'h28, 32'h8);
    wr(32'h24, 32'h800);
    wr(32'h18, 32'hFFFF_FFFF);
    rd(32'h18, v); chk("R9 override holds status", v, 32'h4001);
    wr(32'h28, 32'h0);
    wr(32'h18, 32'h4001);
    rd(32'h18, v); chk("R9 clear after override off", v, 32'h0);

    // R4 channel decode
    wr(32'h60, 32'hCAFE_0001);
    chk("R4 ch2 transmit write strobe", 32'(obsWr), 32'h4);
    chk("R4 ch2 transmit index", 32'(obsIdx), 32'h3);
    chk("R4 ch2 write data", obsWdata, 32'hCAFE_0001);
    rd(32'h78, v);
    chk("R4 ch3 receive read strobe", 32'(obsRd), 32'h8);
    chk("R4 ch3 receive index", 32'(obsIdx), 32'h4);
    chk("R4 ch3 read data", v, 32'hA5C3_0F96);
    wr(32'h2C, 32'h1);
    chk("R4 ch0 config strobe", 32'(obsWr), 32'h1);

    // R3 read-only channel registers
    wr(32'h44, 32'hFFFF_FFFF);
    chk("R3 ch1 status no strobe", 32'(obsWr), 32'h0);
    wr(32'h3C, 32'hFFFF_FFFF);
    chk("R3 ch0 receive no strobe", 32'(obsWr), 32'h0);

    // R11 narrow and unaligned accesses
    access(1'b1, 1'b0, 32'h1C, 32'h7);
    rd(32'h1C, v); chk("R11 narrow write dropped", v, 32'h10);
    access(1'b0, 1'b0, 32'h00, 32'h0);
    chk("R11 narrow read zero", obsRdata, 32'h0);
    access(1'b1, 1'b0, 32'h2C, 32'h1);
    chk("R11 narrow no strobe", 32'(obsWr), 32'h0);
    access(1'b1, 1'b1, 32'h1D, 32'h7);
    rd(32'h1C, v); chk("R11 unaligned write dropped", v, 32'h10);

    // R12 unmapped reads
    rd(32'h04, v); chk("R12 hole reads zero", v, 32'h0);
    rd(32'h7C, v); chk("R12 past last window", v, 32'h0);
    chk("R12 past last window no strobe", 32'(obsRd), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule